// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of a digitized signal. It counts the rising edges of that signal inside a time window of fixed length. One of two pulse sources is counted: the AM source or the FM source. The FM source always passes through a divide-by-two stage before it reaches the counter. The window is built from a 1 kHz timebase tick that the block receives. Its length is 1, 4 or 8 tick periods.

Software starts a measurement with one write to a 4-bit mode port. That write picks the source and the window length. The block then waits for the next tick, counts edges until the window has run out, and raises a one-cycle done pulse. The 16-bit result is presented as a low byte and a high byte. A chip-enable input gates the whole block. While it is low, nothing is counted, mode writes are ignored, and any measurement in progress is dropped without a done pulse.

Both inputs must already be clean logic levels that are synchronous to the system clock. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset both result halves read zero, and `busy_o` and `done_irq_o` are low.
- R2: With mode bit 2 = 0, every rising edge of `am_pulse_i` seen inside the window adds one to the result. `fm_pulse_i` has no effect.
- R3: With mode bit 2 = 1, the divide-by-two stage is cleared at the start, and only the 2nd, 4th, 6th... rising edges of `fm_pulse_i` inside the window add one. `am_pulse_i` has no effect.
- R4: Mode bits [1:0] set the window length: 01 = 1 tick period, 10 = 4, 11 = 8. The window opens on the first tick after the mode write. It closes on the tick that ends the chosen number of tick periods. Edges are counted from the cycle after the opening tick up to and including the closing tick cycle.
- R5: `busy_o` is high from the cycle after an accepted nonzero write until the window closes. `done_irq_o` is high for exactly one cycle, namely the cycle after the closing tick.
- R6: A mode write with nonzero bits [1:0] clears the result. The result reads zero from the next cycle on. Such a write also restarts a measurement that is already running.
- R7: A mode write with bits [1:0] = 00 stops any measurement at once, keeps the result as it is, and raises no done pulse.
- R8: While `chip_en_i` is low, no edge is counted, a running measurement ends without a done pulse, mode writes are ignored, and the result holds its value.
- R9: The result saturates at its all-ones value and does not wrap.
- R10: `cnt_lo_o` carries result bits [7:0] and `cnt_hi_o` carries bits [15:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Block enable; low aborts and freezes |
| tick_1k_i | input | 1 | One-cycle pulse once per 1 kHz period |
| am_pulse_i | input | 1 | AM pulse input, counted directly |
| fm_pulse_i | input | 1 | FM pulse input, counted after divide-by-two |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 4 | Mode value: [1:0] window, [2] source, [3] unused |
| cnt_lo_o | output | 8 | Result low byte |
| cnt_hi_o | output | 8 | Result high byte |
| busy_o | output | 1 | Measurement pending or window open |
| done_irq_o | output | 1 | One-cycle pulse when a window closes |

## Verification
Counting works on the edge seen in a cycle, so an input level presented in cycle k is reflected in the result read in cycle k+1. A mode write has the same one-cycle delay: it clears the result and raises `busy_o` one cycle later. The done pulse and the drop of `busy_o` appear in the cycle after the closing tick. The bench drives everything on the falling clock edge and generates the tick itself. Because it knows which cycle holds the closing tick, it reads the result, `done_irq_o` and `busy_o` exactly one cycle later, and it checks again one cycle after that to confirm that the pulse has ended.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_OPEN  = 2'd2
  } gate_st_e;

  typedef struct packed {
    logic       spare;
    logic       use_fm;
    logic [1:0] gate_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/ifc_edge_prescale.sv
module ifc_edge_prescale #(
  parameter int FM_DIV_LOG2 = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic am_i,
  input  logic fm_i,
  input  logic use_fm_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pulse_o
);

  logic am_q, fm_q;
  logic am_rise, fm_rise;

  assign am_rise = am_i & ~am_q;
  assign fm_rise = fm_i & ~fm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q <= 1'b0;
      fm_q <= 1'b0;
    end else begin
      am_q <= am_i;
      fm_q <= fm_i;
    end
  end

  logic fm_out;

  generate
    if (FM_DIV_LOG2 == 0) begin : g_fm_direct
      assign fm_out = fm_rise;
    end else begin : g_fm_div
      logic [FM_DIV_LOG2-1:0] div_q, div_d;
      logic                   fm_step;

      assign fm_step = en_i & use_fm_i & fm_rise;

      always_comb begin
        div_d = div_q;
        if (clr_i) begin
          div_d = '0;
        end else if (fm_step) begin
          div_d = div_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          div_q <= '0;
        end else begin
          div_q <= div_d;
        end
      end

      assign fm_out = fm_rise & (&div_q);
    end
  endgenerate

  assign pulse_o = en_i & (use_fm_i ? fm_out : am_rise);

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && !at_max) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9: once at the top, the value stays there until a clear
  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && !clr_i) |=> (cnt_q == CNT_MAX));

  // R8: without an increment or a clear, the value does not move
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

  // R6: a clear request gives zero in the next cycle
  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/ifc_gate_ctrl.sv
module ifc_gate_ctrl
  import ifc_pkg::*;
#(
  parameter int LEN_SHORT = 1,
  parameter int LEN_MID   = 4,
  parameter int LEN_LONG  = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  chip_en_i,
  input  logic  tick_i,
  input  logic  mode_we_i,
  input  mode_t mode_i,
  output logic  arm_o,
  output logic  open_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  use_fm_o
);

  localparam int LEN_A   = (LEN_SHORT > LEN_MID) ? LEN_SHORT : LEN_MID;
  localparam int LEN_MAX = (LEN_A > LEN_LONG) ? LEN_A : LEN_LONG;
  localparam int TICK_W  = $clog2(LEN_MAX + 1);

  function automatic logic [TICK_W-1:0] sel_len(input logic [1:0] sel);
    case (sel)
      2'b01:   sel_len = TICK_W'(LEN_SHORT);
      2'b10:   sel_len = TICK_W'(LEN_MID);
      2'b11:   sel_len = TICK_W'(LEN_LONG);
      default: sel_len = '0;
    endcase
  endfunction

  gate_st_e          state_q, state_d;
  logic [TICK_W-1:0] left_q, left_d;
  logic              done_q, done_d;
  logic              fm_q, fm_d;
  logic              wr_ok;

  assign wr_ok = chip_en_i & mode_we_i;
  assign arm_o = wr_ok & (mode_i.gate_sel != 2'b00);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    done_d  = 1'b0;
    fm_d    = fm_q;
    if (!chip_en_i) begin
      state_d = ST_IDLE;
      left_d  = '0;
    end else if (mode_we_i) begin
      fm_d = mode_i.use_fm;
      if (mode_i.gate_sel != 2'b00) begin
        state_d = ST_ARMED;
        left_d  = sel_len(mode_i.gate_sel);
      end else begin
        state_d = ST_IDLE;
        left_d  = '0;
      end
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (tick_i) begin
            state_d = ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (tick_i) begin
            if (left_q <= TICK_W'(1)) begin
              state_d = ST_IDLE;
              left_d  = '0;
              done_d  = 1'b1;
            end else begin
              left_d = left_q - 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
      fm_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      done_q  <= done_d;
      fm_q    <= fm_d;
    end
  end

  assign open_o   = (state_q == ST_OPEN) & chip_en_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign use_fm_o = fm_q;

  // R5: the done pulse lasts a single cycle
  assert_irq_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R5: a done pulse only follows a tick seen while the window was open
  assert_irq_after_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q == ST_OPEN && tick_i));

  // R8: chip enable low leaves the gate idle with no done pulse
  assert_ce_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> (state_q == ST_IDLE && !done_q));

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FM_DIV_LOG2 = 1,
  parameter int LEN_SHORT   = 1,
  parameter int LEN_MID     = 4,
  parameter int LEN_LONG    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chip_en_i,
  input  logic                 tick_1k_i,
  input  logic                 am_pulse_i,
  input  logic                 fm_pulse_i,
  input  logic                 mode_we_i,
  input  logic [3:0]           mode_wdata_i,
  output logic [CNT_W/2-1:0]   cnt_lo_o,
  output logic [CNT_W/2-1:0]   cnt_hi_o,
  output logic                 busy_o,
  output logic                 done_irq_o
);

  localparam int HALF_W = CNT_W / 2;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mode_t            mode_w;
  logic             arm, open, use_fm, pulse;
  logic [CNT_W-1:0] cnt;

  assign mode_w = mode_t'(mode_wdata_i[MODE_W-1:0]);

  ifc_gate_ctrl #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_MID   (LEN_MID),
    .LEN_LONG  (LEN_LONG)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .chip_en_i (chip_en_i),
    .tick_i    (tick_1k_i),
    .mode_we_i (mode_we_i),
    .mode_i    (mode_w),
    .arm_o     (arm),
    .open_o    (open),
    .busy_o    (busy_o),
    .done_o    (done_irq_o),
    .use_fm_o  (use_fm)
  );

  ifc_edge_prescale #(
    .FM_DIV_LOG2 (FM_DIV_LOG2)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .am_i     (am_pulse_i),
    .fm_i     (fm_pulse_i),
    .use_fm_i (use_fm),
    .en_i     (open),
    .clr_i    (arm),
    .pulse_o  (pulse)
  );

  ifc_sat_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .clr_i  (arm),
    .inc_i  (pulse),
    .cnt_o  (cnt)
  );

  assign cnt_lo_o = cnt[HALF_W-1:0];
  assign cnt_hi_o = cnt[CNT_W-1:HALF_W];

  // R5: counting happens only while a measurement is in progress
  assert_count_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    pulse |-> busy_o);

  // R8: no count pulse reaches the counter while chip enable is low
  assert_no_count_ce_low_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !chip_en_i |-> !pulse);

endmodule

// File: tb/ifc_gated_counter_bench.sv
`timescale 1ns/1ps
module ifc_gated_counter_bench;

  localparam int TP = 50;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce, tick, am, fm, we;
  logic [3:0] wd;
  logic [7:0] lo, hi;
  logic [1:0] s_lo, s_hi;
  logic       busy, irq, s_busy, s_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  ifc_gated_counter u_ifc_gated_counter (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .tick_1k_i(tick),
    .am_pulse_i(am), .fm_pulse_i(fm), .mode_we_i(we), .mode_wdata_i(wd),
    .cnt_lo_o(lo), .cnt_hi_o(hi), .busy_o(busy), .done_irq_o(irq)
  );

  ifc_gated_counter #(.CNT_W(4)) u_ifc_gated_counter_sat (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .tick_1k_i(tick),
    .am_pulse_i(am), .fm_pulse_i(fm), .mode_we_i(we), .mode_wdata_i(wd),
    .cnt_lo_o(s_lo), .cnt_hi_o(s_hi), .busy_o(s_busy), .done_irq_o(s_irq)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int result();
    return int'({hi, lo});
  endfunction

  function automatic int small_result();
    return int'({s_hi, s_lo});
  endfunction

  function automatic int gate_len(input logic [1:0] g);
    case (g)
      2'b01:   return 1;
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit next_is_tick();
    return ((cyc + 1) % TP) == 0;
  endfunction

  task automatic drive(input logic a, input logic f);
    @(negedge clk);
    cyc++;
    tick = (cyc % TP) == 0;
    am   = a;
    fm   = f;
    we   = 1'b0;
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk);
    cyc++;
    tick = (cyc % TP) == 0;
    am   = 1'b0;
    fm   = 1'b0;
    we   = 1'b1;
    wd   = m;
  endtask

  // wait until the bench has driven a tick cycle, selected input held low on it
  task automatic wait_open(input logic use_fm, input bit noise);
    while (!tick) begin
      bit   nt  = next_is_tick();
      logic lvl = (noise && !nt) ? logic'($urandom % 2) : 1'b0;
      logic oth = logic'($urandom % 2);
      drive(use_fm ? oth : lvl, use_fm ? lvl : oth);
    end
  endtask

  task automatic measure(input logic use_fm, input logic [1:0] g, input bit alt);
    int   len   = gate_len(g) * TP;
    int   edges = 0;
    int   exp_v;
    logic prev  = 1'b0;
    write_mode({1'b0, use_fm, g});
    drive(1'b0, 1'b0);
    check(result() == 0, "R6 result cleared after write", result(), 0);
    check(busy == 1'b1, "R5 busy after write", int'(busy), 1);
    wait_open(use_fm, 1'b1);
    for (int i = 0; i < len; i++) begin
      logic lvl = alt ? logic'(i % 2 == 0) : logic'($urandom % 2);
      logic oth = logic'($urandom % 2);
      drive(use_fm ? oth : lvl, use_fm ? lvl : oth);
      if (lvl && !prev) edges++;
      prev = lvl;
      if (i == len / 2) begin
        check(busy == 1'b1 && irq == 1'b0, "R5 busy mid window", int'({busy, irq}), 2);
      end
    end
    exp_v = use_fm ? edges / 2 : edges;
    drive(1'b0, 1'b0);
    check(irq == 1'b1, "R5 done pulse after close", int'(irq), 1);
    check(busy == 1'b0, "R5 busy low after close", int'(busy), 0);
    check(result() == exp_v, use_fm ? "R3 R4 R10 FM result" : "R2 R4 R10 AM result",
          result(), exp_v);
    check(small_result() == ((exp_v > 15) ? 15 : exp_v), "R9 saturated result",
          small_result(), (exp_v > 15) ? 15 : exp_v);
    drive(1'b0, 1'b0);
    check(irq == 1'b0, "R5 done pulse single cycle", int'(irq), 0);
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin
    int e;
    bit saw_irq;
    logic prev;
    void'($urandom(32'd4099));
    rst_n = 1'b0; ce = 1'b1; tick = 1'b0; am = 1'b0; fm = 1'b0; we = 1'b0; wd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 1'b0);
    check(result() == 0 && small_result() == 0, "R1 result after reset", result(), 0);
    check(busy == 1'b0 && irq == 1'b0, "R1 flags after reset", int'({busy, irq}), 0);

    // directed: exact window lengths with alternating levels
    measure(1'b0, 2'b01, 1'b1);
    measure(1'b0, 2'b11, 1'b1);
    measure(1'b1, 2'b10, 1'b1);

    // random mix
    for (int k = 0; k < 6; k++) begin
      logic [1:0] g = 2'($urandom % 3 + 1);
      measure(logic'($urandom % 2), g, 1'b0);
    end

    // restart: a running measurement is restarted by a new nonzero write
    write_mode(4'b0010);
    wait_open(1'b0, 1'b0);
    for (int i = 0; i < 30; i++) drive(logic'(i % 2 == 0), 1'b0);
    check(result() == 15, "R6 partial count before restart", result(), 15);
    measure(1'b0, 2'b01, 1'b0);

    // gate 00 write stops the window and keeps the result
    write_mode(4'b0011);
    wait_open(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) drive(logic'(i % 2 == 0), 1'b0);
    write_mode(4'b0000);
    drive(1'b0, 1'b0);
    check(busy == 1'b0, "R7 stop write drops busy", int'(busy), 0);
    saw_irq = 1'b0;
    for (int i = 0; i < 450; i++) begin
      drive(logic'(i % 2 == 0), 1'b0);
      if (irq) saw_irq = 1'b1;
    end
    check(!saw_irq, "R7 no done pulse after stop", int'(saw_irq), 0);
    check(result() == 10, "R7 result kept after stop", result(), 10);

    // chip enable drop mid window
    write_mode(4'b0011);
    wait_open(1'b0, 1'b0);
    e = 0; prev = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic lvl = logic'($urandom % 2);
      drive(lvl, 1'b0);
      if (lvl && !prev) e++;
      prev = lvl;
    end
    @(negedge clk);
    cyc++; tick = (cyc % TP) == 0; ce = 1'b0; am = ~prev; fm = 1'b0;
    drive(1'b0, 1'b0);
    check(busy == 1'b0, "R8 busy low after chip enable drop", int'(busy), 0);
    check(result() == e, "R8 result frozen at drop", result(), e);
    saw_irq = 1'b0;
    for (int i = 0; i < 450; i++) begin
      drive(logic'(i % 2 == 0), logic'(i % 2 == 0));
      if (irq) saw_irq = 1'b1;
    end
    check(!saw_irq, "R8 no done pulse after abort", int'(saw_irq), 0);
    check(result() == e, "R8 result held while disabled", result(), e);
    write_mode(4'b0001);
    drive(1'b0, 1'b0);
    check(busy == 1'b0 && result() == e, "R8 write ignored while disabled",
          result(), e);
    ce = 1'b1;
    drive(1'b0, 1'b0);

    // final FM check after re-enable
    measure(1'b1, 2'b01, 1'b0);

    summary();
  end

endmodule